// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A table of two-bit saturating counters holds the guesses. A shift register records the outcomes of recently resolved branches. At fetch, the word-aligned part of the branch address is XOR-combined with that outcome history to select one counter. The upper bit of that counter is the guess. The block returns the guess together with the table index it used.

When the branch later resolves, the pipeline hands back the branch address, the index returned at fetch, and the real outcome. The block moves the chosen counter one step toward the outcome and shifts the outcome into the history. The update uses the index captured at fetch, so history shifts made in between do not send the update to the wrong entry.

By default the table has 2048 counters, selected by 11 address bits above a 2-bit alignment field, and the history is 8 bits wide.

Top module: `gsharePredictor`

## Requirements
- R1: On each cycle with `resolveValid` high, the history shifts left by one and takes the resolved outcome (taken = 1) into bit 0. On a cycle without `resolveValid`, the history holds its value.
- R2: A resolved taken outcome increments the counter at `resolveIndex`. A counter already at 3 stays at 3.
- R3: A resolved not-taken outcome decrements the counter at `resolveIndex`. A counter already at 0 stays at 0.
- R4: `predTaken` equals bit 1 of the selected counter. It is 1 for counter values 2 and 3, and 0 for values 0 and 1.
- R5: `predIndex` equals `fetchPc[12:2]` XOR the history zero-extended to 11 bits, so the history lands on index bits 7:0. This output is combinational from `fetchPc` and the current history.
- R6: After reset every counter holds 1 (weakly not-taken) and the history is zero. `predIndex` then equals `fetchPc[12:2]` and `predTaken` is 0 for every address.
- R7: An update changes only the counter named by `resolveIndex`, regardless of the current history. `resolvePc[12:10]` must agree with `resolveIndex[10:8]`.
- R8: When the fetch index and `resolveIndex` name the same entry in one cycle, `predTaken` shows the value from before the update. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| fetchPc | input | 32 | Address of the branch being fetched |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predIndex | output | 11 | Table index used for this prediction |
| resolveValid | input | 1 | A branch outcome is being reported this cycle |
| resolvePc | input | 32 | Address of the resolving branch |
| resolveIndex | input | 11 | Index that was returned when this branch was fetched |
| resolveTaken | input | 1 | Real outcome, 1 = taken |

## Verification
The assertions assume that every reported resolution carries an index that really came from the same branch address. The upper index bits, which the history never touches, must therefore match the address bits they were taken from. The random stimulus builds each resolve address from its chosen index so that this agreement always holds. The stimulus otherwise mixes arbitrary indices, outcomes, and idle cycles. Directed sequences walk a single counter across both saturation limits and make fetch and update collide on one entry.

// File: rtl/gsharePkg.sv
package gsharePkg;

  // Strobes passed from the control to the datapath for one resolve cycle.
  typedef struct packed {
    logic cntWrite;   // the selected counter changes this cycle
    logic cntInc;     // step upward
    logic cntDec;     // step downward
    logic histShift;  // shift the outcome history
    logic histBit;    // value entering the history
  } gshareStrobe_t;

  localparam logic [1:0] CNT_MAX  = 2'd3;
  localparam logic [1:0] CNT_MIN  = 2'd0;
  localparam logic [1:0] CNT_INIT = 2'd1;

endpackage

// File: rtl/gshareCtrl.sv
module gshareCtrl
  import gsharePkg::*;
(
  input  logic          resolveValid,
  input  logic          resolveTaken,
  input  logic [1:0]    updCount,
  output gshareStrobe_t strobe
);

  logic atTop;
  logic atBottom;

  assign atTop    = (updCount == CNT_MAX);
  assign atBottom = (updCount == CNT_MIN);

  always_comb begin
    strobe           = '0;
    strobe.histShift = resolveValid;
    strobe.histBit   = resolveTaken;
    if (resolveValid) begin
      if (resolveTaken && !atTop) begin
        strobe.cntInc   = 1'b1;
        strobe.cntWrite = 1'b1;
      end else if (!resolveTaken && !atBottom) begin
        strobe.cntDec   = 1'b1;
        strobe.cntWrite = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gshareDatapath.sv
module gshareDatapath
  import gsharePkg::*;
#(
  parameter int IDX_W  = 11,
  parameter int HIST_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] lookupSlice,
  input  logic [IDX_W-1:0] updIndex,
  input  gshareStrobe_t    strobe,
  output logic [IDX_W-1:0] lookupIndex,
  output logic [1:0]       lookupCount,
  output logic [1:0]       updCount
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [HIST_W-1:0] history;
  logic [IDX_W-1:0]  histAligned;
  logic [1:0]        cntTable [ENTRIES];
  logic [1:0]        nextCount;

  // Line the history up with the low index bits.
  generate
    if (HIST_W >= IDX_W) begin : gHistWide
      assign histAligned = history[IDX_W-1:0];
    end else begin : gHistNarrow
      assign histAligned = {{(IDX_W-HIST_W){1'b0}}, history};
    end
  endgenerate

  assign lookupIndex = lookupSlice ^ histAligned;
  assign lookupCount = cntTable[lookupIndex];
  assign updCount    = cntTable[updIndex];

  always_comb begin
    nextCount = updCount;
    if (strobe.cntInc)      nextCount = updCount + 2'd1;
    else if (strobe.cntDec) nextCount = updCount - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      history <= '0;
    end else if (strobe.histShift) begin
      history <= {history[HIST_W-2:0], strobe.histBit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) cntTable[i] <= CNT_INIT;
    end else if (strobe.cntWrite) begin
      cntTable[updIndex] <= nextCount;
    end
  end

  // R1: the history moves exactly when an outcome is reported.
  assert_hist_shift_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.histShift |=> history == {$past(history[HIST_W-2:0]), $past(strobe.histBit)});

  assert_hist_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.histShift |=> $stable(history));

  // R2: after a taken outcome the entry cannot sit at the bottom.
  assert_taken_floor_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.histShift && strobe.histBit) |=> cntTable[$past(updIndex)] != CNT_MIN);

  // R3: after a not-taken outcome the entry cannot sit at the top.
  assert_nottaken_ceiling_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.histShift && !strobe.histBit) |=> cntTable[$past(updIndex)] != CNT_MAX);

endmodule

// File: rtl/gsharePredictor.sv
module gsharePredictor
  import gsharePkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 11,
  parameter int HIST_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  output logic             predTaken,
  output logic [IDX_W-1:0] predIndex,
  input  logic             resolveValid,
  input  logic [PC_W-1:0]  resolvePc,
  input  logic [IDX_W-1:0] resolveIndex,
  input  logic             resolveTaken
);

  localparam int SLICE_LO = ALIGN_W;
  localparam int SLICE_HI = ALIGN_W + IDX_W - 1;
  localparam int PURE_W   = (IDX_W > HIST_W) ? (IDX_W - HIST_W) : 0;

  gshareStrobe_t    strobe;
  logic [1:0]       lookupCount;
  logic [1:0]       updCount;
  logic [IDX_W-1:0] fetchSlice;
  logic             unusedPcBits;

  assign fetchSlice   = fetchPc[SLICE_HI:SLICE_LO];
  assign unusedPcBits = ^{fetchPc, resolvePc};

  gshareCtrl uCtrl (
    .resolveValid (resolveValid),
    .resolveTaken (resolveTaken),
    .updCount     (updCount),
    .strobe       (strobe)
  );

  gshareDatapath #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .lookupSlice (fetchSlice),
    .updIndex    (resolveIndex),
    .strobe      (strobe),
    .lookupIndex (predIndex),
    .lookupCount (lookupCount),
    .updCount    (updCount)
  );

  assign predTaken = lookupCount[1];

  // R7: index bits above the history must come straight from the resolving address.
  generate
    if (PURE_W > 0) begin : gPureCheck
      assert_pc_index_agree_R7: assert property (@(posedge clk) disable iff (!rstN)
        resolveValid |-> resolvePc[SLICE_HI -: PURE_W] == resolveIndex[IDX_W-1 -: PURE_W]);
    end
  endgenerate

  // R6: straight after reset no address may be predicted taken.
  assert_reset_weak_R6: assert property (@(posedge clk)
    !rstN |=> !predTaken);

endmodule

// File: tb/gsharePredictor_test.sv
`timescale 1ns/1ps
module gsharePredictor_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        predTaken;
  logic [10:0] predIndex;
  logic        resolveValid = 1'b0;
  logic [31:0] resolvePc = '0;
  logic [10:0] resolveIndex = '0;
  logic        resolveTaken = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [1:0] mCnt [2048];
  logic [7:0] mHist;

  always #2 clk = ~clk;

  gsharePredictor uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predTaken(predTaken),
    .predIndex(predIndex), .resolveValid(resolveValid), .resolvePc(resolvePc),
    .resolveIndex(resolveIndex), .resolveTaken(resolveTaken)
  );

  function automatic logic [10:0] idxOf(logic [31:0] pc);
    return pc[12:2] ^ {3'b000, mHist};
  endfunction

  function automatic logic [31:0] pcFor(logic [10:0] idx);
    logic [31:0] pc;
    pc = $urandom;
    pc[12:2] = idx ^ {3'b000, mHist};
    return pc;
  endfunction

  function automatic logic [31:0] resPcFor(logic [10:0] idx);
    logic [31:0] pc;
    pc = $urandom;
    pc[12:10] = idx[10:8];
    return pc;
  endfunction

  function automatic logic [1:0] stepCnt(logic [1:0] c, logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: drive, compare combinational outputs, then advance the model.
  task automatic cycle(string req, logic [31:0] pc, logic rv, logic [10:0] ridx, logic rt);
    logic [10:0] ei;
    @(negedge clk);
    fetchPc = pc;
    resolveValid = rv;
    resolveIndex = ridx;
    resolvePc = resPcFor(ridx);
    resolveTaken = rt;
    #1;
    ei = idxOf(pc);
    check({req, " index"}, 32'(predIndex), 32'(ei));
    check({req, " taken"}, 32'(predTaken), 32'(mCnt[ei][1]));
    @(posedge clk);
    if (rv) begin
      mCnt[ridx] = stepCnt(mCnt[ridx], rt);
      mHist = {mHist[6:0], rt};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] tgt;
    logic [10:0] pend [4];
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 2048; i++) mCnt[i] = 2'd1;
    mHist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R6: reset state, history zero and all entries weakly not-taken
    for (int k = 0; k < 6; k++) begin
      logic [31:0] pc;
      pc = $urandom;
      cycle("R6 reset", pc, 1'b0, 11'd0, 1'b0);
    end

    // R2/R4: walk one entry upward past saturation
    tgt = 11'h155;
    for (int k = 0; k < 4; k++) cycle("R2 climb", pcFor(tgt), 1'b1, tgt, 1'b1);
    cycle("R2 at top R4", pcFor(tgt), 1'b0, 11'd0, 1'b0);
    // one step down from 3 must still predict taken (no wrap to 0)
    cycle("R3 from top", pcFor(tgt), 1'b1, tgt, 1'b0);
    cycle("R4 value2", pcFor(tgt), 1'b0, 11'd0, 1'b0);
    // R3: walk downward past zero
    for (int k = 0; k < 4; k++) cycle("R3 fall", pcFor(tgt), 1'b1, tgt, 1'b0);
    cycle("R3 at bottom", pcFor(tgt), 1'b1, tgt, 1'b1);
    cycle("R3 no wrap", pcFor(tgt), 1'b0, 11'd0, 1'b0);

    // R8: fetch and update hit the same entry in one cycle
    tgt = 11'h2a7;
    cycle("R8 prime", pcFor(tgt), 1'b1, tgt, 1'b1);
    cycle("R8 collide", pcFor(tgt), 1'b1, tgt, 1'b1);
    cycle("R8 after", pcFor(tgt), 1'b0, 11'd0, 1'b0);

    // R7: update at a stored index that no longer matches the fetch mapping
    tgt = 11'h0f3;
    for (int k = 0; k < 3; k++) cycle("R7 stale idx", 32'h0000_1000, 1'b1, tgt, 1'b1);
    cycle("R7 read back", pcFor(tgt), 1'b0, 11'd0, 1'b0);

    // R1/R5: history pattern visible through predIndex at a fixed address
    for (int k = 0; k < 10; k++) cycle("R1 R5 hist", 32'h0000_0abc, 1'b1, 11'h7ff, k[0]);
    cycle("R1 idle hold", 32'h0000_0abc, 1'b0, 11'd0, 1'b0);
    cycle("R1 idle hold", 32'h0000_0abc, 1'b0, 11'd0, 1'b0);

    // Random mix: resolves reuse recently predicted indices
    for (int k = 0; k < 4; k++) pend[k] = 11'($urandom);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] pc;
      logic rv;
      int slot;
      pc = ($urandom % 4 == 0) ? pcFor(pend[0]) : {$urandom} & 32'h0000_3ffc;
      rv = ($urandom % 3) != 0;
      slot = $urandom % 4;
      cycle("R5 R7 random", pc, rv, pend[slot], 1'($urandom % 4 != 0));
      pend[slot] = idxOf(pc);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule